// File: doc/BRIEF.md
# Synchronizable Periodic Interrupt Timer

This block is a bank of independent periodic timers that share one bus clock. Each channel counts down through a programmable period. At the end of every period it reloads, sets a sticky flag and pulses its own trigger output for one clock, so that other peripherals can start work on that event. A single interrupt line merges the flags of the channels whose interrupt is enabled.

Channel phases can be aligned in two ways. A command write reloads any chosen set of channels on the same clock edge. A rising edge on one selected external sync input reloads a programmed set of channels. That sync edge also starts a short schedule of up to three delayed converter-start pulses, each at its own programmed distance from the edge. Software can request an extra converter pulse at any time.

Register map (word addresses): 0 control (run enables in bits [7:0], interrupt enables in bits [15:8]); 1 sync setup (source select in [1:0], schedule slot enables in [4:2], sync restart mask in [12:5]); 2 command (write only: reload mask in [7:0], software converter pulse in bit 8; reads as zero); 3 flags (read in [7:0], write one to clear); 4 to 11 the period field of channels 0 to 7; 12 to 14 the delay of schedule slots 0 to 2.

Top module: `pit_sync_bank`

## Requirements
- R1: After reset every trigger output, the converter pulse and the interrupt are low, the flags read 0, and the sync setup register reads 3 (source select 3 means no source).
- R2: A channel whose period field holds F and whose run bit is set at clock edge W pulses its trigger high for one cycle after edges W+P, W+2P and so on, where P = F+1; with F = 0 the trigger stays high.
- R3: Channels with different period fields run at the same time without affecting one another's pulse timing.
- R4: A flag is set on every time-out of its channel and holds until a one is written to its bit at address 3; a time-out on the same edge as the clear write leaves the flag set.
- R5: The interrupt output goes high one cycle after a flag is set whose interrupt enable is also set, and it stays low while all interrupt enables are zero.
- R6: A command write with reload mask bits set reloads those channels on the write edge, so their next pulses follow R2 counted from that edge.
- R7: A rising edge on the sync input picked by source select (0 to 2) reloads the channels in the restart mask as in R6 and starts the schedule; edges on the other inputs, or any edge while select is 3, have no effect.
- R8: Each enabled schedule slot with delay D raises the converter pulse for one cycle after edge Es+D+1, where Es is the edge that detects the sync; disabled slots never pulse.
- R9: A new sync edge restarts the schedule: pulses still pending from the old one are dropped, and all enabled slots are timed again from the new edge.
- R10: A command write with bit 8 set raises the converter pulse for the single cycle after the write edge.
- R11: A channel whose run bit is clear never pulses and never sets its flag; setting the run bit starts a full period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 24 | Register write data |
| bus_rdata | output | 24 | Registered read data for the address of the previous cycle |
| sync_in | input | 3 | External sync inputs, synchronous to clk |
| trig_out | output | 8 | Per-channel time-out trigger pulses |
| conv_trig | output | 1 | Converter start pulse (schedule or software) |
| irq | output | 1 | Interrupt request |

## Verification
A down-counter that holds the wrong value moves the channel's trigger pulse away from its expected slot. The error shows on the first pulse after a start, reload or sync and repeats every period after that. A wrong pending set or schedule count makes a converter pulse appear or disappear at a delay that can be predicted, at most delay+1 cycles after the sync edge. A flag register that is stuck or not cleared shows in the flag readback and, with its enable set, on the interrupt line one cycle later.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int REG_CTRL     = 0;
  localparam int REG_SYNC     = 1;
  localparam int REG_CMD      = 2;
  localparam int REG_FLAG     = 3;
  localparam int REG_PER_BASE = 4;
endpackage

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          load,
  input  logic          clr,
  input  logic [CW-1:0] period,
  output logic          trig,
  output logic          flag
);
  logic [CW-1:0] cnt;
  logic          expire;

  assign expire = run && !load && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      trig <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (!run || load || cnt == '0) cnt <= period;
      else                           cnt <= cnt - 1'b1;
      trig <= expire;
      if (expire)   flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  AST_TRIG_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    trig |-> flag);                                     // R4
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run |=> !trig);                                    // R11
  AST_LOAD_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    load |=> !trig);                                    // R6
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    trig |-> (cnt == $past(period)));                   // R2
endmodule

// File: rtl/pit_sched.sv
module pit_sched #(
  parameter int NSLOT = 3,
  parameter int DW    = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       sw,
  input  logic [NSLOT-1:0]           slot_en,
  input  logic [NSLOT-1:0][DW-1:0]   delay,
  output logic                       conv
);
  logic [DW-1:0]    tcnt;
  logic [NSLOT-1:0] pend;
  logic [NSLOT-1:0] hit;

  always_comb begin
    for (int k = 0; k < NSLOT; k++)
      hit[k] = pend[k] && !start && (tcnt == delay[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt <= '0;
      pend <= '0;
      conv <= 1'b0;
    end else begin
      if (start) begin
        tcnt <= '0;
        pend <= slot_en;
      end else begin
        pend <= pend & ~hit;
        if (|pend) tcnt <= tcnt + 1'b1;
      end
      conv <= (|hit) || sw;
    end
  end

  AST_PEND_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($countones(pend) <= $countones($past(pend))));  // R9
  AST_IDLE_NO_CONV: assert property (@(posedge clk) disable iff (rst)
    (pend == '0 && !sw) |=> !conv);                             // R8
endmodule

// File: rtl/pit_sync_bank.sv
module pit_sync_bank #(
  parameter int NCH   = 8,
  parameter int CW    = 24,
  parameter int NSRC  = 3,
  parameter int NSLOT = 3,
  parameter int DW    = 16,
  parameter int AW    = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [CW-1:0]  bus_wdata,
  output logic [CW-1:0]  bus_rdata,
  input  logic [NSRC-1:0] sync_in,
  output logic [NCH-1:0] trig_out,
  output logic           conv_trig,
  output logic           irq
);
  import pit_pkg::*;

  localparam int SELW     = $clog2(NSRC + 1);
  localparam int SLOT_LSB = SELW;
  localparam int RM_LSB   = SELW + NSLOT;
  localparam int DLY_BASE = REG_PER_BASE + NCH;

  logic [NCH-1:0]             run_q, ie_q, rmask_q;
  logic [SELW-1:0]            sel_q;
  logic [NSLOT-1:0]           slot_en_q;
  logic [NCH-1:0][CW-1:0]     per_q;
  logic [NSLOT-1:0][DW-1:0]   dly_q;
  logic [NSRC-1:0]            sync_q;
  logic [NCH-1:0]             flags, ld_vec, clr_vec;
  logic                       sync_evt, wr_cmd, sw_conv;
  logic [CW-1:0]              rd_next;

  always_comb begin
    sync_evt = 1'b0;
    for (int s = 0; s < NSRC; s++)
      if (sel_q == SELW'(s) && sync_in[s] && !sync_q[s]) sync_evt = 1'b1;
  end

  assign wr_cmd  = bus_we && (bus_addr == AW'(REG_CMD));
  assign sw_conv = wr_cmd && bus_wdata[NCH];
  assign ld_vec  = (wr_cmd ? bus_wdata[NCH-1:0] : '0) | (sync_evt ? rmask_q : '0);
  assign clr_vec = (bus_we && bus_addr == AW'(REG_FLAG)) ? bus_wdata[NCH-1:0] : '0;

  always_comb begin
    rd_next = '0;
    if (bus_addr == AW'(REG_CTRL)) rd_next = CW'({ie_q, run_q});
    if (bus_addr == AW'(REG_SYNC)) rd_next = CW'({rmask_q, slot_en_q, sel_q});
    if (bus_addr == AW'(REG_FLAG)) rd_next = CW'(flags);
    for (int i = 0; i < NCH; i++)
      if (bus_addr == AW'(REG_PER_BASE + i)) rd_next = per_q[i];
    for (int j = 0; j < NSLOT; j++)
      if (bus_addr == AW'(DLY_BASE + j)) rd_next = CW'(dly_q[j]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= '0;
      ie_q      <= '0;
      rmask_q   <= '0;
      sel_q     <= SELW'(NSRC);
      slot_en_q <= '0;
      per_q     <= '0;
      dly_q     <= '0;
      sync_q    <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      sync_q    <= sync_in;
      irq       <= |(flags & ie_q);
      bus_rdata <= rd_next;
      if (bus_we) begin
        if (bus_addr == AW'(REG_CTRL)) {ie_q, run_q} <= bus_wdata[2*NCH-1:0];
        if (bus_addr == AW'(REG_SYNC)) begin
          sel_q     <= bus_wdata[SELW-1:0];
          slot_en_q <= bus_wdata[SLOT_LSB +: NSLOT];
          rmask_q   <= bus_wdata[RM_LSB +: NCH];
        end
        for (int i = 0; i < NCH; i++)
          if (bus_addr == AW'(REG_PER_BASE + i)) per_q[i] <= bus_wdata;
        for (int j = 0; j < NSLOT; j++)
          if (bus_addr == AW'(DLY_BASE + j)) dly_q[j] <= bus_wdata[DW-1:0];
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pit_channel #(.CW(CW)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .run    (run_q[g]),
      .load   (ld_vec[g]),
      .clr    (clr_vec[g]),
      .period (per_q[g]),
      .trig   (trig_out[g]),
      .flag   (flags[g])
    );
  end

  pit_sched #(.NSLOT(NSLOT), .DW(DW)) u_sched (
    .clk     (clk),
    .rst     (rst),
    .start   (sync_evt),
    .sw      (sw_conv),
    .slot_en (slot_en_q),
    .delay   (dly_q),
    .conv    (conv_trig)
  );

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (ie_q == '0) |=> !irq);                               // R5
  AST_SYNC_OFF_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SELW'(NSRC)) |-> !sync_evt);                // R7
endmodule

// File: tb/pit_sync_bank_tb.sv
module pit_sync_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [23:0] bus_wdata = '0;
  logic [23:0] bus_rdata;
  logic [2:0]  sync_in = '0;
  logic [7:0]  trig_out;
  logic        conv_trig;
  logic        irq;
  int total = 0;
  int bad = 0;
  int k = 0;

  always #10 clk = ~clk;

  pit_sync_bank u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_in(sync_in),
    .trig_out(trig_out), .conv_trig(conv_trig), .irq(irq)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    k++;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = 24'(d);
    @(negedge clk);
    bus_we = 1'b0;
    k = 0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 4'(a);
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic psync(logic [2:0] b);
    step(); sync_in = b;
    step(); sync_in = '0;
  endtask

  function automatic int syncw(int sel, int slots, int rm);
    return sel | (slots << 2) | (rm << 5);
  endfunction

  task automatic t_reset();
    int v;
    chk("R1 trig", int'(trig_out), 0);
    chk("R1 conv", int'(conv_trig), 0);
    chk("R1 irq", int'(irq), 0);
    rd(3, v); chk("R1 flags", v, 0);
    rd(1, v); chk("R1 sync setup", v, 3);
  endtask

  task automatic t_period();
    wr(4, 4); wr(5, 6); wr(6, 0);
    wr(0, 8'h07);
    for (int i = 1; i <= 21; i++) begin
      step();
      chk("R2 ch0 P=5", int'(trig_out[0]), int'(k % 5 == 0));
      chk("R3 ch1 P=7", int'(trig_out[1]), int'(k % 7 == 0));
      chk("R2 ch2 P=1", int'(trig_out[2]), 1);
    end
    wr(0, 0);
  endtask

  task automatic t_flag();
    int v;
    rd(3, v); chk("R4 sticky flags", v, 7);
    wr(3, 1); rd(3, v); chk("R4 clear bit0", v, 6);
    wr(3, 6); rd(3, v); chk("R4 clear rest", v, 0);
    wr(6, 0); wr(0, 8'h04);
    step(); step(); step();
    wr(3, 4); rd(3, v); chk("R4 set beats clear", v, 4);
    wr(0, 0); wr(3, 8'hFF); rd(3, v); chk("R4 cleared", v, 0);
  endtask

  task automatic t_irq();
    wr(4, 2); wr(0, 1);
    for (int i = 0; i < 5; i++) step();
    chk("R5 no enable", int'(irq), 0);
    wr(0, 1 | (1 << 8));
    step(); chk("R5 irq on", int'(irq), 1);
    wr(0, 0);
    step(); chk("R5 irq off", int'(irq), 0);
    wr(3, 8'hFF);
  endtask

  task automatic t_load();
    wr(4, 4); wr(5, 6); wr(0, 8'h03);
    step(); step(); step();
    wr(2, 3);
    for (int i = 1; i <= 15; i++) begin
      step();
      chk("R6 ch0 aligned", int'(trig_out[0]), int'(k % 5 == 0));
      chk("R6 ch1 aligned", int'(trig_out[1]), int'(k % 7 == 0));
    end
    wr(0, 0); wr(3, 8'hFF);
  endtask

  task automatic t_sync();
    wr(7, 9); wr(12, 0);
    wr(1, syncw(1, 1, 8'h08));
    wr(0, 8'h08);
    step(); step(); step();
    psync(3'b101);
    while (k < 12) begin
      step();
      chk("R7 other src ignored trig", int'(trig_out[3]), int'(k == 10));
      chk("R7 other src ignored conv", int'(conv_trig), 0);
    end
    psync(3'b010);
    while (k < 26) begin
      step();
      chk("R7 selected restart trig", int'(trig_out[3]), int'(k == 24));
      chk("R7 selected conv", int'(conv_trig), int'(k == 15));
    end
    wr(1, syncw(3, 1, 8'h08));
    psync(3'b111);
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R7 select off conv", int'(conv_trig), 0);
    end
    wr(0, 0); wr(3, 8'hFF);
  endtask

  task automatic t_sched();
    wr(12, 3); wr(13, 10); wr(14, 6);
    wr(1, syncw(0, 3'b101, 0));
    psync(3'b001); k = 0;
    for (int i = 1; i <= 14; i++) begin
      step();
      chk("R8 slot order", int'(conv_trig), int'(k == 4 || k == 7));
    end
    wr(1, syncw(0, 3'b111, 0));
    psync(3'b001); k = 0;
    for (int i = 1; i <= 5; i++) begin
      step();
      chk("R9 first run", int'(conv_trig), int'(k == 4));
    end
    psync(3'b001);
    chk("R9 old slot dropped", int'(conv_trig), 0);
    while (k < 20) begin
      step();
      chk("R9 restarted", int'(conv_trig), int'(k == 11 || k == 14 || k == 18));
    end
  endtask

  task automatic t_sw();
    wr(2, 1 << 8);
    chk("R10 sw pulse", int'(conv_trig), 1);
    chk("R10 no channel reload pulse", int'(trig_out), 0);
    step();
    chk("R10 single cycle", int'(conv_trig), 0);
  endtask

  task automatic t_idle();
    int v;
    wr(8, 1);
    for (int i = 0; i < 8; i++) begin
      step();
      chk("R11 stopped quiet", int'(trig_out), 0);
    end
    rd(3, v); chk("R11 no flag", v, 0);
    wr(0, 8'h10);
    for (int i = 1; i <= 6; i++) begin
      step();
      chk("R11 full first period", int'(trig_out[4]), int'(k % 2 == 0));
    end
    wr(0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_period();
    t_flag();
    t_irq();
    t_load();
    t_sync();
    t_sched();
    t_sw();
    t_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule